// File: doc/BRIEF.md
# Load-Use Interlock with Test Pipeline Shell

This block finds read-after-write conflicts between the instruction being decoded and the instruction in the execute stage of a five-stage in-order pipeline that has no bypass network. When such a conflict appears, the block stalls the front of the pipeline for one cycle. The program counter and the fetch/decode register keep their values during that cycle. An empty operation is loaded into the decode/execute register, so the execute stage still receives something on every clock. On the next cycle the producing instruction has moved on to the memory stage and the held instruction continues.

A minimal pipeline shell comes with the block so that it can be tested on its own. The shell has a program counter that counts in whole instructions, a fetch/decode register, a decode/execute register and an execute/memory register. Instruction memory is outside the block. It returns the word for the current program counter in the same cycle. The execute and memory stage contents are brought out so that the exact entry cycle of every instruction can be observed.

Top module: `lui_pipe_top`

## Requirements
- R1: After reset the program counter is 0, the execute and memory stages hold no valid instruction, and all three stall controls are low.
- R2: The instruction word is laid out as follows: bits 4:0 hold the destination register, bits 9:5 source A, bits 14:10 source B, bit 15 the write enable, bit 16 the source-A-used flag and bit 17 the source-B-used flag. A stall is raised when the decoding instruction is valid, a used source equals the destination of a valid writing instruction in execute, and that destination is nonzero. The program counter then holds its value across the next edge.
- R3: During a stall, the fetch/decode register keeps the waiting instruction, so it reaches execute with its own program counter.
- R4: On the edge after a stall, execute receives an empty slot with valid 0 and write enable 0.
- R5: A stall lasts exactly one cycle. The dependent instruction enters execute two edges after its producer did.
- R6: A producer whose destination is register 0 never causes a stall.
- R7: A producer with write enable 0 never causes a stall.
- R8: A source whose used flag is 0 never causes a stall, even when its index matches.
- R9: On every cycle without a stall, the program counter advances by one, and consecutive instructions enter execute on consecutive edges.
- R10: Only the execute-stage instruction is compared. A matching writer already in the memory stage causes no stall, and each instruction moves from execute to memory on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_data_i | input | 18 | Instruction word at the current program counter |
| pc_o | output | 8 | Fetch program counter, in instructions |
| pc_hold_o | output | 1 | Program counter hold for the coming edge |
| ifid_hold_o | output | 1 | Fetch/decode register hold for the coming edge |
| bubble_o | output | 1 | Load an empty slot into decode/execute on the coming edge |
| ex_valid_o | output | 1 | Execute stage holds a real instruction |
| ex_pc_o | output | 8 | Program counter of the execute-stage instruction |
| ex_rd_o | output | 5 | Destination register in execute |
| ex_wen_o | output | 1 | Write enable in execute |
| mem_valid_o | output | 1 | Memory stage holds a real instruction |
| mem_pc_o | output | 8 | Program counter of the memory-stage instruction |

## Verification
Assertions check four things on every cycle. After a stall the program counter and the held decode word stay unchanged. An empty slot follows every stall, and stalls never come on two cycles in a row. Producers to register 0, non-writing producers and decoding instructions with no used sources never stall. Whether the whole schedule is right can only be shown by the bench, which compares it against an arithmetic model. That model gives the entry edge of every instruction and the program counter after every edge. The bench sweeps generated programs: dependency chains, independent streams, register-0 writers, disabled writes, unused matching sources, and writers that are two instructions back.

// File: rtl/lui_pkg.sv
package lui_pkg;
    localparam int REG_W  = 5;
    localparam int PC_W   = 8;
    localparam int NSRC   = 2;
    localparam int INSN_W = NSRC * REG_W + REG_W + 1 + NSRC;

    typedef logic [REG_W-1:0] reg_idx_t;
    typedef logic [PC_W-1:0]  pc_t;

    // Field order sets the word layout: used flags on top, destination at bit 0.
    typedef struct packed {
        logic     use_b;
        logic     use_a;
        logic     wen;
        reg_idx_t src_b;
        reg_idx_t src_a;
        reg_idx_t dst;
    } insn_t;

    typedef struct packed {
        logic  valid;
        pc_t   pc;
        insn_t insn;
    } stage_t;

    function automatic stage_t empty_slot();
        stage_t s;
        s = '0;
        return s;
    endfunction
endpackage

// File: rtl/lui_hazard.sv
module lui_hazard
    import lui_pkg::*;
(
    input  stage_t id_i,
    input  stage_t ex_i,
    output logic   stall_o
);
    reg_idx_t        src   [NSRC];
    logic [NSRC-1:0] used;
    logic [NSRC-1:0] hit;
    logic            writer;

    always_comb begin
        src[0]  = id_i.insn.src_a;
        src[1]  = id_i.insn.src_b;
        used[0] = id_i.insn.use_a;
        used[1] = id_i.insn.use_b;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
        assign hit[s] = used[s] && (src[s] == ex_i.insn.dst);
    end

    assign writer  = ex_i.valid && ex_i.insn.wen && (ex_i.insn.dst != '0);
    assign stall_o = id_i.valid && writer && (|hit);
endmodule

// File: rtl/lui_fetch.sv
module lui_fetch
    import lui_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic [INSN_W-1:0] imem_i,
    output pc_t               pc_o,
    output stage_t            id_o
);
    typedef struct packed {
        pc_t    pc;
        stage_t ifid;
    } fe_state_t;

    fe_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold_i) begin
            st_d.pc         = st_q.pc + PC_W'(1);
            st_d.ifid.valid = 1'b1;
            st_d.ifid.pc    = st_q.pc;
            st_d.ifid.insn  = insn_t'(imem_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o = st_q.pc;
    assign id_o = st_q.ifid;

    a_r3_ifid_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(st_q.ifid));
    a_r2_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(pc_o));
    a_r9_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |=> (pc_o == $past(pc_o) + PC_W'(1)));
endmodule

// File: rtl/lui_exec.sv
module lui_exec
    import lui_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bubble_i,
    input  stage_t id_i,
    output stage_t ex_o,
    output stage_t mem_o
);
    typedef struct packed {
        stage_t idex;
        stage_t exmem;
    } bk_state_t;

    bk_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.idex  = bubble_i ? empty_slot() : id_i;
        st_d.exmem = st_q.idex;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ex_o  = st_q.idex;
    assign mem_o = st_q.exmem;

    a_r4_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_i |=> (!ex_o.valid && !ex_o.insn.wen));
    a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
        ex_o.valid |=> (mem_o.valid && mem_o.pc == $past(ex_o.pc)));
endmodule

// File: rtl/lui_pipe_top.sv
module lui_pipe_top
    import lui_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] imem_data_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              pc_hold_o,
    output logic              ifid_hold_o,
    output logic              bubble_o,
    output logic              ex_valid_o,
    output logic [PC_W-1:0]   ex_pc_o,
    output logic [REG_W-1:0]  ex_rd_o,
    output logic              ex_wen_o,
    output logic              mem_valid_o,
    output logic [PC_W-1:0]   mem_pc_o
);
    stage_t id_s, ex_s, mem_s;
    logic   stall;
    pc_t    pc_s;

    lui_hazard u_hazard (
        .id_i    (id_s),
        .ex_i    (ex_s),
        .stall_o (stall)
    );

    lui_fetch u_fetch (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (stall),
        .imem_i (imem_data_i),
        .pc_o   (pc_s),
        .id_o   (id_s)
    );

    lui_exec u_exec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bubble_i (stall),
        .id_i     (id_s),
        .ex_o     (ex_s),
        .mem_o    (mem_s)
    );

    assign pc_o        = pc_s;
    assign pc_hold_o   = stall;
    assign ifid_hold_o = stall;
    assign bubble_o    = stall;
    assign ex_valid_o  = ex_s.valid;
    assign ex_pc_o     = ex_s.pc;
    assign ex_rd_o     = ex_s.insn.dst;
    assign ex_wen_o    = ex_s.insn.wen;
    assign mem_valid_o = mem_s.valid;
    assign mem_pc_o    = mem_s.pc;

    a_r5_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    a_r6_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd_o == '0) |-> !pc_hold_o);
    a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_wen_o |-> !pc_hold_o);
    a_r8_no_sources: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_s.insn.use_a && !id_s.insn.use_b) |-> !bubble_o);
endmodule

// File: tb/lui_pipe_top_tb_top.sv
module lui_pipe_top_tb_top;
    import lui_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PLEN       = 100;
    localparam int MAXC       = 512;
    localparam int NRUNS      = 9;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [INSN_W-1:0] imem;
    logic [PC_W-1:0]   pc, ex_pc, mem_pc;
    logic [REG_W-1:0]  ex_rd;
    logic              pc_hold, ifid_hold, bubble, ex_valid, ex_wen, mem_valid;

    insn_t prog [2**PC_W];
    int    entry [PLEN];
    int    slot  [MAXC];
    bit    hold_at [MAXC];
    string why_at  [MAXC];
    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 1'b0;
    logic [31:0] lcg;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign imem = prog[pc];

    lui_pipe_top dut_i (
        .clk(clk), .rst_n(rst_n), .imem_data_i(imem), .pc_o(pc),
        .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold), .bubble_o(bubble),
        .ex_valid_o(ex_valid), .ex_pc_o(ex_pc), .ex_rd_o(ex_rd), .ex_wen_o(ex_wen),
        .mem_valid_o(mem_valid), .mem_pc_o(mem_pc)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit raw_match(insn_t c, insn_t p, bit honour_use);
        return ((c.use_a || !honour_use) && c.src_a == p.dst) ||
               ((c.use_b || !honour_use) && c.src_b == p.dst);
    endfunction

    function automatic bit conflict(insn_t c, insn_t p);
        return p.wen && (p.dst != 0) && raw_match(c, p, 1'b1);
    endfunction

    function automatic string reason(int i);
        if (conflict(prog[i], prog[i-1]))                          return "R2";
        if (prog[i-1].wen && prog[i-1].dst != 0 && raw_match(prog[i], prog[i-1], 1'b0)) return "R8";
        if (prog[i-1].dst == 0 && raw_match(prog[i], prog[i-1], 1'b1)) return "R6";
        if (!prog[i-1].wen && raw_match(prog[i], prog[i-1], 1'b1))   return "R7";
        if (i >= 2 && conflict(prog[i], prog[i-2]))                return "R10";
        return "R9";
    endfunction

    function automatic logic [31:0] step(logic [31:0] v);
        return v * 32'd1103515245 + 32'd12345;
    endfunction

    task automatic gen(input int mode, input int seed);
        insn_t w;
        lcg = 32'(seed);
        for (int i = 0; i < 2**PC_W; i++) begin
            lcg = step(lcg);
            w = '0;
            case (mode)
                1: begin w.dst = REG_W'((i % 3) + 1); w.wen = 1'b1; w.use_a = 1'b1;
                         w.src_a = (i == 0) ? '0 : REG_W'(((i - 1) % 3) + 1); end
                2: begin w.dst = REG_W'((i % 4) + 4); w.wen = 1'b1; w.use_a = 1'b1;
                         w.use_b = 1'b1; w.src_a = 5'd1; w.src_b = 5'd2; end
                3: begin w.wen = 1'b1; w.use_a = 1'b1; w.use_b = 1'b1; end
                4: begin w.dst = 5'd1; w.src_a = 5'd1; w.src_b = 5'd1;
                         w.use_a = 1'b1; w.use_b = 1'b1; end
                5: begin w.dst = 5'd2; w.src_a = 5'd2; w.src_b = 5'd2; w.wen = 1'b1; end
                6: begin if (i % 2 == 0) begin w.dst = 5'd3; w.wen = 1'b1;
                         w.src_a = 5'd3; w.use_a = 1'b1; end end
                default: begin
                    w.dst = REG_W'(lcg[17:16]); w.src_a = REG_W'(lcg[19:18]);
                    w.src_b = REG_W'(lcg[21:20]); w.wen = lcg[22];
                    w.use_a = lcg[23]; w.use_b = lcg[24];
                end
            endcase
            prog[i] = w;
        end
    endtask

    task automatic build_model();
        for (int n = 0; n < MAXC; n++) begin slot[n] = -1; hold_at[n] = 1'b0; why_at[n] = "R9"; end
        entry[0] = 2;
        slot[2]  = 0;
        for (int i = 1; i < PLEN; i++) begin
            bit h;
            h = conflict(prog[i], prog[i-1]);
            hold_at[entry[i-1]] = h;
            why_at[entry[i-1]]  = reason(i);
            entry[i] = entry[i-1] + 1 + int'(h);
            slot[entry[i]] = i;
        end
    endtask

    task automatic run(input int mode, input int seed);
        int exp_pc;
        string t;
        rst_n = 1'b0;
        gen(mode, seed);
        build_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n  = 1'b1;
        exp_pc = 0;
        for (int n = 0; n <= entry[PLEN-1]; n++) begin
            t = (n == 0) ? "R1" : (hold_at[n] ? "R2" : "R9");
            chk(pc == PC_W'(exp_pc), t, "pc", int'(pc), exp_pc % (2**PC_W));
            if (n < entry[PLEN-1]) begin
                t = (n == 0) ? "R1" : why_at[n];
                chk(pc_hold == hold_at[n], t, "pc_hold", int'(pc_hold), int'(hold_at[n]));
                chk(ifid_hold == hold_at[n], (n == 0) ? "R1" : "R3", "ifid_hold", int'(ifid_hold), int'(hold_at[n]));
                chk(bubble == hold_at[n], (n == 0) ? "R1" : "R4", "bubble", int'(bubble), int'(hold_at[n]));
            end
            if (slot[n] >= 0) begin
                t = (slot[n] > 0 && conflict(prog[slot[n]], prog[slot[n]-1])) ? "R5 R3" : "R9";
                chk(ex_valid && ex_pc == PC_W'(slot[n]), t, "ex_pc", ex_valid ? int'(ex_pc) : -1, slot[n]);
            end else begin
                t = (n == 0) ? "R1" : "R4";
                chk(!ex_valid && !ex_wen, t, "ex_empty", int'({ex_valid, ex_wen}), 0);
            end
            if (n > 0 && slot[n-1] >= 0)
                chk(mem_valid && mem_pc == PC_W'(slot[n-1]), "R10", "mem_pc",
                    mem_valid ? int'(mem_pc) : -1, slot[n-1]);
            else
                chk(!mem_valid, (n == 0) ? "R1" : "R10", "mem_empty", int'(mem_valid), 0);
            @(posedge clk);
            @(negedge clk);
            if (!hold_at[n]) exp_pc++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        for (int r = 0; r < NRUNS; r++) begin
            run((r < 7) ? r : 0, 17 + r * 7919);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule